// File: doc/BRIEF.md
# Multi-Supply Reset Hold Controller

This block decides when a system may leave reset. Three undervoltage flags, each already produced and synchronized by an external comparator, and one active-low manual reset pin feed it. The block drives a single active-low reset output. That output goes low as soon as any supply flag is raised or an accepted manual press is seen. It stays low until every cause has been gone for a full hold period.

The hold period is measured in ticks of a clock-enable timebase. A 2-bit select input picks one of four tick counts, and each count is a parameter. With a 1 ms tick, the default counts give 50, 100, 200 and 400 ms. Select code 2 (200 ms) is the default and is the code loaded at power-on.

The manual pin passes through a two-flop synchronizer and then a glitch filter. A low pulse must last a minimum number of clocks before it counts as a press. If any cause returns while the hold is counting, the count starts over. A synchronous power-on input forces the output low and clears all state.

Top module: `sup_reset_gen`

## Requirements
- R1: While any bit of `supply_low` is 1 at a clock edge, `rst_n` is 0 after that edge.
- R2: A low level on `mr_n` lasting at least FILT_CYC clocks is accepted as a press. `rst_n` is 0 no later than FILT_CYC+3 edges after `mr_n` first goes low.
- R3: Once all causes have cleared and `tick` is 1 every cycle, `rst_n` stays 0 for exactly N edges, counting from the first edge that sees no cause, and then goes to 1. N is the tick count of the selected code. `rst_n` rises only at an edge where `tick` was 1 and no supply flag was set.
- R4: A low pulse on `mr_n` shorter than FILT_CYC clocks has no effect, and `rst_n` stays 1.
- R5: Select codes map to tick counts as follows: 2'b00 gives TICKS_C0, 2'b01 gives TICKS_C1, 2'b10 gives TICKS_C2, and 2'b11 gives TICKS_C3. `tsel` is captured on every edge at which reset is asserted.
- R6: If a cause returns during the hold count, `rst_n` stays 0 and the count restarts from zero when the cause clears again.
- R7: The hold count advances only on edges where `tick` is 1. With `tick` held at 0, `rst_n` stays 0 indefinitely.
- R8: While `por` is 1, `rst_n` is 0 after each edge. Power-on clears the count and loads select code 2'b10.
- R9: After an accepted manual press, `rst_n` returns to 1 exactly N+3 edges after `mr_n` goes high, with `tick` 1 every cycle and no supply flag set. Two of the extra edges come from the synchronizer and one from the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high |
| supply_low | input | 3 | Undervoltage flags, one per supply, active high |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| tick | input | 1 | Timebase clock enable |
| tsel | input | 2 | Hold period select code |
| rst_n | output | 1 | Reset output, active low |

## Verification
A wrong hold counter or a wrong select capture shows up as a release edge that arrives early or late. The bench therefore checks the output on the edge just before the expected release and on the release edge itself, for each select code and after a restart. A filter counter that saturates at the wrong value either lets a short press through or drops a valid one. Either fault changes `rst_n` within a few clocks of the pulse. A synchronizer or filter that fails to clear after a press leaves reset held. The exact N+3 release check catches that fault within one period.

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int TICKS_C0 = 50,
  parameter int TICKS_C1 = 100,
  parameter int TICKS_C2 = 200,
  parameter int TICKS_C3 = 400,
  parameter int FILT_CYC = 25,
  localparam int MAX_A = (TICKS_C0 > TICKS_C1) ? TICKS_C0 : TICKS_C1,
  localparam int MAX_B = (TICKS_C2 > TICKS_C3) ? TICKS_C2 : TICKS_C3,
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CNT_W = $clog2(MAX_T + 1),
  localparam int FW = $clog2(FILT_CYC + 1)
) (
  input  logic       clk,
  input  logic       por,
  input  logic [2:0] supply_low,
  input  logic       mr_n,
  input  logic       tick,
  input  logic [1:0] tsel,
  output logic       rst_n
);

  logic             s1, s2;
  logic [FW-1:0]    flt;
  logic             mr_act;
  logic             cause;
  logic             held;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [1:0]       sel_q;

  always_ff @(posedge clk) begin
    if (por) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= mr_n;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (por || s2)
      flt <= '0;
    else if (flt != FW'(FILT_CYC))
      flt <= flt + 1'b1;
  end

  assign mr_act = (flt == FW'(FILT_CYC));
  assign cause  = (|supply_low) | mr_act;

  always_comb begin
    case (sel_q)
      2'b00:   lim = CNT_W'(TICKS_C0 - 1);
      2'b01:   lim = CNT_W'(TICKS_C1 - 1);
      2'b10:   lim = CNT_W'(TICKS_C2 - 1);
      default: lim = CNT_W'(TICKS_C3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (por) begin
      held  <= 1'b1;
      cnt   <= '0;
      sel_q <= 2'b10;
    end else begin
      if (held)
        sel_q <= tsel;
      if (cause) begin
        held <= 1'b1;
        cnt  <= '0;
      end else if (held && tick) begin
        if (cnt >= lim) begin
          held <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign rst_n = ~held;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter int FILT_CYC = 25,
  localparam int LOW_LIM = FILT_CYC + 3,
  localparam int LW = $clog2(LOW_LIM + 1)
) (
  input logic       clk,
  input logic       por,
  input logic [2:0] supply_low,
  input logic       mr_n,
  input logic       tick,
  input logic       rst_n
);

  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (por || mr_n)
      low_run <= '0;
    else if (low_run != LW'(LOW_LIM))
      low_run <= low_run + 1'b1;
  end

  // R1
  supply_asserts_chk: assert property (@(posedge clk) disable iff (por)
    (supply_low != 3'b000) |=> !rst_n);

  // R8
  por_forces_chk: assert property (@(posedge clk)
    por |=> !rst_n);

  // R3
  release_on_tick_chk: assert property (@(posedge clk) disable iff (por)
    $rose(rst_n) |-> ($past(tick) && ($past(supply_low) == 3'b000)));

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (por)
    (!rst_n && !tick) |=> !rst_n);

  // R2
  manual_accept_chk: assert property (@(posedge clk) disable iff (por)
    (low_run == LW'(LOW_LIM)) |-> !rst_n);

endmodule

bind sup_reset_gen sup_reset_gen_chk #(.FILT_CYC(FILT_CYC)) u_chk (
  .clk(clk),
  .por(por),
  .supply_low(supply_low),
  .mr_n(mr_n),
  .tick(tick),
  .rst_n(rst_n)
);

// File: tb/sim_sup_reset_gen.sv
module sim_sup_reset_gen;

  localparam int C0 = 3;
  localparam int C1 = 5;
  localparam int C2 = 8;
  localparam int C3 = 12;
  localparam int FC = 4;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic [2:0] supply_low = 3'b000;
  logic       mr_n = 1'b1;
  logic       tick = 1'b1;
  logic [1:0] tsel = 2'b10;
  logic       rst_n;

  typedef struct {
    logic  v;
    string tag;
  } exp_t;

  exp_t sb[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sup_reset_gen #(
    .TICKS_C0(C0), .TICKS_C1(C1), .TICKS_C2(C2), .TICKS_C3(C3), .FILT_CYC(FC)
  ) u0 (
    .clk(clk), .por(por), .supply_low(supply_low), .mr_n(mr_n),
    .tick(tick), .tsel(tsel), .rst_n(rst_n)
  );

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    exp_t it;
    #1;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      compared++;
      if (rst_n !== it.v) begin
        mismatched++;
        $display("FAIL %s: rst_n=%0b expected %0b", it.tag, rst_n, it.v);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    edges(3);
    expect_out(1'b0, "R8 held during power-on");
    por = 1'b0;
    edges(C2 - 1); expect_out(1'b0, "R3 R8 default code before release");
    edges(1);      expect_out(1'b1, "R3 R8 default code release");

    tsel = 2'b00; supply_low = 3'b001;
    edges(1); expect_out(1'b0, "R1 flag bit0");
    edges(2); supply_low = 3'b000;
    edges(C0 - 1); expect_out(1'b0, "R3 code00 before release");
    edges(1);      expect_out(1'b1, "R3 code00 release");

    tsel = 2'b01; supply_low = 3'b010;
    edges(1); expect_out(1'b0, "R1 flag bit1");
    edges(1); supply_low = 3'b000;
    edges(C1 - 1); expect_out(1'b0, "R5 code01 before release");
    edges(1);      expect_out(1'b1, "R5 code01 release");

    tsel = 2'b11; supply_low = 3'b100;
    edges(1); expect_out(1'b0, "R1 flag bit2");
    edges(1); supply_low = 3'b000;
    edges(C3 - 1); expect_out(1'b0, "R5 code11 before release");
    edges(1);      expect_out(1'b1, "R5 code11 release");

    tsel = 2'b00; supply_low = 3'b001;
    edges(1); supply_low = 3'b000;
    edges(2); expect_out(1'b0, "R6 mid count");
    supply_low = 3'b001;
    edges(1); expect_out(1'b0, "R6 cause returns");
    supply_low = 3'b000;
    edges(C0 - 1); expect_out(1'b0, "R6 restarted count");
    edges(1);      expect_out(1'b1, "R6 release after restart");

    tick = 1'b0; supply_low = 3'b010;
    edges(1); supply_low = 3'b000;
    edges(20); expect_out(1'b0, "R7 no tick holds");
    tick = 1'b1;
    edges(C0 - 1); expect_out(1'b0, "R7 ticks resume");
    edges(1);      expect_out(1'b1, "R7 release");

    edges(2);
    mr_n = 1'b0;
    edges(FC - 1);
    mr_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      edges(1); expect_out(1'b1, "R4 short pulse rejected");
    end

    mr_n = 1'b0;
    edges(FC);
    mr_n = 1'b1;
    edges(3); expect_out(1'b0, "R2 minimum pulse accepted");
    edges(30); expect_out(1'b1, "R2 released after press");

    mr_n = 1'b0;
    edges(10); expect_out(1'b0, "R9 held press");
    mr_n = 1'b1;
    edges(C0 + 2); expect_out(1'b0, "R9 before release");
    edges(1);      expect_out(1'b1, "R9 release");

    edges(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule